// File: doc/BRIEF.md
# SIMM Bank Address Decoder

This block turns a physical address into the number of the memory socket that serves it and the byte offset inside that socket's module. Up to six sockets hold modules of 8 MB or 32 MB. Each socket's size is reported on a static size-code input. Modules are fitted in pairs of equal size, with the 32 MB pairs placed first from socket 0 upward. The decode is purely combinational from registered window state, over a 32-bit address.

Window state comes from one of two sources. The first is a list of end-address entries that software writes in 8 MB units. Writing entry `k` (1 to 6) sets up socket `k-1`. Its base is the stored value of entry `k-1`, or zero for socket 0. It is switched off when the new end value equals that base. The second source is an auto-layout sequencer, which runs once after reset when the strap `auto_cfg` is high. Its state machine has three named states:
- `LAY_START`: the reset state. It leaves for `LAY_WALK` when the strap is high and for `LAY_DONE` otherwise.
- `LAY_WALK`: one cycle per socket, in ascending order. Each populated socket is placed at the running sum of the sizes below it. The transition to `LAY_DONE` happens after the last socket.
- `LAY_DONE`: terminal. The decoder is only live in this state.

Where windows overlap, the socket with the higher number wins.

Top module: `simm_bank_decoder`

## Requirements
- R1: After reset with `auto_cfg` low, no socket is enabled, and every address gives `hit`=0, `sock`=0, `offset`=0.
- R2: With `auto_cfg` high at reset, every populated socket is enabled at the running sum of the sizes of the lower populated sockets, in ascending order. Size code 2'b01 means 8 MB, 2'b10 means 32 MB, and 2'b00 or 2'b11 means empty. Socket k's code sits at `pop_code[2k+1:2k]`.
- R3: Until the layout sequence ends, `hit` stays 0 and end-entry writes are ignored. The sequence ends after 7 clock edges past reset release with the strap high, and after 1 edge with it low.
- R4: A write of value v to entry k (1 to 6) while socket k-1 is populated takes effect at the capturing edge. Socket k-1's base becomes the stored entry k-1 (0 for k=1). The socket is enabled exactly when v differs from that base. Units are 8 MB, so the address is shifted by 23.
- R5: An enabled socket matches addresses in [base, base + module size). A socket switched off by a zero span never matches.
- R6: Writes to entry 0 or entry 7, and writes that target an unpopulated socket, change no decode result.
- R7: When several socket windows contain the address, `sock` reports the highest matching socket number.
- R8: On a hit, `offset` equals the address minus the selected socket's base. On a miss, `hit`=0, `sock`=0 and `offset`=0.
- R9: The decode has no latency. The outputs follow `addr` in the same cycle, and a write becomes visible only after its capturing edge.
- R10: A socket's base is the entry value captured when that socket was programmed. Rewriting the lower entry afterwards does not move the socket until its own entry is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_cfg | input | 1 | Strap that selects automatic contiguous layout after reset |
| pop_code | input | 12 | Per-socket size codes, 2 bits each |
| cfg_we | input | 1 | End-entry write strobe |
| cfg_idx | input | 3 | End-entry number |
| cfg_end | input | 5 | End address in 8 MB units |
| addr | input | 32 | Physical address to decode |
| hit | output | 1 | Address falls in an enabled socket |
| sock | output | 3 | Selected socket number |
| offset | output | 32 | Byte offset within the selected socket |

## Verification
A lookup and a reprogramming write can fall in the same cycle. The bench provokes this by presenting an address inside socket 3 while it writes an end value that collapses socket 3's span to zero. Before the edge, the scoreboard expects the old hit. In the following cycle it expects a miss, with the address held unchanged. The bench also overlaps writes with the layout walk and requires both that they are dropped and that `hit` stays low.

// File: rtl/simm_dec_pkg.sv
package simm_dec_pkg;

    typedef enum logic [1:0] {
        LAY_START,
        LAY_WALK,
        LAY_DONE
    } lay_state_e;

    localparam logic [1:0] SZ_CODE_8MB  = 2'b01;
    localparam logic [1:0] SZ_CODE_32MB = 2'b10;

    // Module size in 8 MB units; reserved and empty codes give zero.
    function automatic logic [2:0] size_units(input logic [1:0] code);
        logic [2:0] u;
        unique case (code)
            SZ_CODE_8MB:  u = 3'd1;
            SZ_CODE_32MB: u = 3'd4;
            default:      u = 3'd0;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/simm_layout_seq.sv
module simm_layout_seq
    import simm_dec_pkg::*;
#(
    parameter int NUM_SOCK = 6,
    parameter int SOCK_W   = 3,
    parameter int BASE_W   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  auto_cfg,
    input  logic [2*NUM_SOCK-1:0] pop_code,
    output logic                  ready,
    output logic                  place_vld,
    output logic [SOCK_W-1:0]     place_idx,
    output logic [BASE_W-1:0]     place_base
);

    localparam logic [SOCK_W-1:0] LAST_SOCK = SOCK_W'(NUM_SOCK - 1);

    lay_state_e        state_q, state_d;
    logic [SOCK_W-1:0] walk_q;
    logic [BASE_W-1:0] sum_q;
    logic [2:0]        cur_units;

    assign cur_units = size_units(pop_code[2*walk_q +: 2]);

    // State register together with the walk counter and running sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LAY_START;
            walk_q  <= '0;
            sum_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == LAY_WALK) begin
                walk_q <= walk_q + 1'b1;
                sum_q  <= sum_q + BASE_W'(cur_units);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LAY_START: state_d = auto_cfg ? LAY_WALK : LAY_DONE;
            LAY_WALK:  state_d = (walk_q == LAST_SOCK) ? LAY_DONE : LAY_WALK;
            LAY_DONE:  state_d = LAY_DONE;
            default:   state_d = LAY_START;
        endcase
    end

    // Output process.
    always_comb begin
        ready      = (state_q == LAY_DONE);
        place_vld  = (state_q == LAY_WALK) && (cur_units != 3'd0);
        place_idx  = walk_q;
        place_base = sum_q;
    end

    assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    assert_walk_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        place_vld |-> (place_idx <= LAST_SOCK) && !ready);

endmodule

// File: rtl/simm_end_file.sv
module simm_end_file #(
    parameter int NUM_SOCK = 6,
    parameter int IDX_W    = 3,
    parameter int END_W    = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [END_W-1:0]                wr_val,
    output logic [(NUM_SOCK-1)*END_W-1:0]   base_src
);

    // Only entries 1..NUM_SOCK-1 ever serve as a base for a higher socket.
    for (genvar j = 1; j < NUM_SOCK; j++) begin : g_ent
        logic [END_W-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(j))) begin
                ent_q <= wr_val;
            end
        end
        assign base_src[(j-1)*END_W +: END_W] = ent_q;
    end

endmodule

// File: rtl/simm_slot.sv
module simm_slot
    import simm_dec_pkg::*;
#(
    parameter int SLOT     = 0,
    parameter int SOCK_W   = 3,
    parameter int IDX_W    = 3,
    parameter int END_W    = 5,
    parameter int ADDR_W   = 32,
    parameter int UNIT_LG2 = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fire,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [END_W-1:0]  cfg_val,
    input  logic [END_W-1:0]  prev_end,
    input  logic [1:0]        size_code,
    input  logic              place_vld,
    input  logic [SOCK_W-1:0] place_idx,
    input  logic [END_W-1:0]  place_base,
    input  logic [ADDR_W-1:0] addr,
    output logic              match,
    output logic [ADDR_W-1:0] offset
);

    logic             en_q;
    logic [END_W-1:0] base_q;
    logic [2:0]       units;
    logic             wr_me;
    logic             place_me;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W:0]   lim_addr;

    assign units    = size_units(size_code);
    assign wr_me    = cfg_fire && (cfg_idx == IDX_W'(SLOT + 1)) && (units != 3'd0);
    assign place_me = place_vld && (place_idx == SOCK_W'(SLOT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            base_q <= '0;
        end else if (place_me) begin
            en_q   <= 1'b1;
            base_q <= place_base;
        end else if (wr_me) begin
            en_q   <= (cfg_val != prev_end);
            base_q <= prev_end;
        end
    end

    always_comb begin
        base_addr = ADDR_W'(base_q) << UNIT_LG2;
        lim_addr  = {1'b0, base_addr} + ((ADDR_W + 1)'(units) << UNIT_LG2);
        match     = en_q && (units != 3'd0) && (addr >= base_addr)
                    && ({1'b0, addr} < lim_addr);
        offset    = addr - base_addr;
    end

    assert_zero_span_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_me && (cfg_val == prev_end)) |=> !match);

    assert_place_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
        place_me |=> en_q);

endmodule

// File: rtl/simm_pick.sv
module simm_pick #(
    parameter int NUM_SOCK = 6,
    parameter int SOCK_W   = 3,
    parameter int ADDR_W   = 32
) (
    input  logic [NUM_SOCK-1:0]        match_vec,
    input  logic [NUM_SOCK*ADDR_W-1:0] off_vec,
    output logic                       hit,
    output logic [SOCK_W-1:0]          sock,
    output logic [ADDR_W-1:0]          offset
);

    // Ascending scan: a later (higher) match overwrites a lower one.
    always_comb begin
        hit    = 1'b0;
        sock   = '0;
        offset = '0;
        for (int i = 0; i < NUM_SOCK; i++) begin
            if (match_vec[i]) begin
                hit    = 1'b1;
                sock   = SOCK_W'(i);
                offset = off_vec[i*ADDR_W +: ADDR_W];
            end
        end
    end

endmodule

// File: rtl/simm_bank_decoder.sv
module simm_bank_decoder #(
    parameter int NUM_SOCK = 6,
    parameter int ADDR_W   = 32,
    parameter int END_W    = 5,
    parameter int UNIT_LG2 = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  auto_cfg,
    input  logic [2*NUM_SOCK-1:0] pop_code,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_idx,
    input  logic [END_W-1:0]      cfg_end,
    input  logic [ADDR_W-1:0]     addr,
    output logic                  hit,
    output logic [2:0]            sock,
    output logic [ADDR_W-1:0]     offset
);

    localparam int IDX_W  = $clog2(NUM_SOCK + 2);
    localparam int SOCK_W = $clog2(NUM_SOCK);

    logic                          ready;
    logic                          place_vld;
    logic [SOCK_W-1:0]             place_idx;
    logic [END_W-1:0]              place_base;
    logic                          cfg_fire;
    logic [(NUM_SOCK-1)*END_W-1:0] base_src;
    logic [NUM_SOCK-1:0]           match_vec;
    logic [NUM_SOCK*ADDR_W-1:0]    off_vec;
    logic                          pick_hit;
    logic [SOCK_W-1:0]             pick_sock;
    logic [ADDR_W-1:0]             pick_off;

    assign cfg_fire = cfg_we && ready;

    simm_layout_seq #(
        .NUM_SOCK (NUM_SOCK),
        .SOCK_W   (SOCK_W),
        .BASE_W   (END_W)
    ) u_layout (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_cfg   (auto_cfg),
        .pop_code   (pop_code),
        .ready      (ready),
        .place_vld  (place_vld),
        .place_idx  (place_idx),
        .place_base (place_base)
    );

    simm_end_file #(
        .NUM_SOCK (NUM_SOCK),
        .IDX_W    (IDX_W),
        .END_W    (END_W)
    ) u_ends (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_fire),
        .wr_idx   (IDX_W'(cfg_idx)),
        .wr_val   (cfg_end),
        .base_src (base_src)
    );

    for (genvar k = 0; k < NUM_SOCK; k++) begin : g_slot
        logic [END_W-1:0] prev_end;
        if (k == 0) begin : g_first
            assign prev_end = '0;
        end else begin : g_rest
            assign prev_end = base_src[(k-1)*END_W +: END_W];
        end

        simm_slot #(
            .SLOT     (k),
            .SOCK_W   (SOCK_W),
            .IDX_W    (IDX_W),
            .END_W    (END_W),
            .ADDR_W   (ADDR_W),
            .UNIT_LG2 (UNIT_LG2)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_fire   (cfg_fire),
            .cfg_idx    (IDX_W'(cfg_idx)),
            .cfg_val    (cfg_end),
            .prev_end   (prev_end),
            .size_code  (pop_code[2*k +: 2]),
            .place_vld  (place_vld),
            .place_idx  (place_idx),
            .place_base (place_base),
            .addr       (addr),
            .match      (match_vec[k]),
            .offset     (off_vec[k*ADDR_W +: ADDR_W])
        );
    end

    simm_pick #(
        .NUM_SOCK (NUM_SOCK),
        .SOCK_W   (SOCK_W),
        .ADDR_W   (ADDR_W)
    ) u_pick (
        .match_vec (match_vec),
        .off_vec   (off_vec),
        .hit       (pick_hit),
        .sock      (pick_sock),
        .offset    (pick_off)
    );

    always_comb begin
        hit    = pick_hit && ready;
        sock   = hit ? 3'(pick_sock) : 3'd0;
        offset = hit ? pick_off : '0;
    end

    assert_busy_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !hit);

    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (sock == 3'd0) && (offset == '0));

    assert_high_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((match_vec >> (sock + 3'd1)) == '0) && match_vec[sock]);

    assert_sock_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (sock < 3'(NUM_SOCK)));

endmodule

// File: tb/test_simm_bank_decoder.sv
`timescale 1ns/1ps
module test_simm_bank_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        auto_cfg = 1'b0;
    logic [11:0] pop_code = 12'h000;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = 3'd0;
    logic [4:0]  cfg_end = 5'd0;
    logic [31:0] addr = 32'd0;
    logic        hit;
    logic [2:0]  sock;
    logic [31:0] offset;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit          q_hit [$];
    logic [2:0]  q_sock [$];
    logic [31:0] q_off [$];
    string       q_tag [$];

    always #4 clk = ~clk;

    simm_bank_decoder i_simm_bank_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_cfg (auto_cfg),
        .pop_code (pop_code),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_end  (cfg_end),
        .addr     (addr),
        .hit      (hit),
        .sock     (sock),
        .offset   (offset)
    );

    // Monitor: compares at the falling edge of the cycle the item was pushed.
    always @(negedge clk) begin
        if (q_tag.size() != 0) begin
            bit          eh;
            logic [2:0]  es;
            logic [31:0] eo;
            string       et;
            eh = q_hit.pop_front();
            es = q_sock.pop_front();
            eo = q_off.pop_front();
            et = q_tag.pop_front();
            n_cmp++;
            if (hit !== eh || sock !== es || offset !== eo) begin
                n_bad++;
                $display("FAIL %s addr=%h: got hit=%0b sock=%0d off=%h, expected hit=%0b sock=%0d off=%h",
                         et, addr, hit, sock, offset, eh, es, eo);
            end
        end
    end

    task automatic push(input bit h, input logic [2:0] s, input logic [31:0] o, input string t);
        q_hit.push_back(h);
        q_sock.push_back(s);
        q_off.push_back(o);
        q_tag.push_back(t);
    endtask

    task automatic look(input logic [31:0] a, input bit h, input logic [2:0] s,
                        input logic [31:0] o, input string t);
        @(posedge clk);
        #1;
        addr = a;
        push(h, s, o, t);
    endtask

    task automatic wr(input logic [2:0] idx, input logic [4:0] v);
        @(posedge clk);
        #1;
        cfg_we  = 1'b1;
        cfg_idx = idx;
        cfg_end = v;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic do_reset(input bit strap, input logic [11:0] pc);
        @(posedge clk);
        #1;
        rst_n    = 1'b0;
        auto_cfg = strap;
        pop_code = pc;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        repeat (10) @(posedge clk);
    endtask

    initial begin
        // Sizes: s0,s1 = 32 MB (code 10), s2,s3 = 8 MB (code 01), s4,s5 empty.
        do_reset(1'b0, 12'h05A);
        look(32'h0000_0000, 0, 0, 0, "R1 no window after reset");
        look(32'h0200_0000, 0, 0, 0, "R1 no window after reset");

        // Program contiguous windows: s0 [0,4) s1 [4,8) s2 [8,9) s3 [9,10) units.
        wr(3'd1, 5'd4);
        wr(3'd2, 5'd8);
        wr(3'd3, 5'd9);
        wr(3'd4, 5'd10);
        look(32'h0000_0010, 1, 0, 32'h0000_0010, "R4 s0");
        look(32'h0200_0000, 1, 1, 32'h0, "R4 s1 base from entry1");
        look(32'h0400_0000, 1, 2, 32'h0, "R4 s2 base from entry2");
        look(32'h047F_FFFF, 1, 2, 32'h007F_FFFF, "R5 s2 top byte");
        look(32'h0480_0000, 1, 3, 32'h0, "R4 s3");
        look(32'h0500_0000, 0, 0, 0, "R8 miss above windows");

        // Zero span disables s2; s3 keeps its old base.
        wr(3'd3, 5'd8);
        look(32'h0400_0000, 0, 0, 0, "R5 zero span disables");
        look(32'h0480_0000, 1, 3, 32'h0, "R10 s3 not moved by entry3 rewrite");
        wr(3'd4, 5'd9);
        look(32'h0400_0000, 1, 3, 32'h0, "R10 s3 rebased on own write");
        look(32'h0480_0000, 0, 0, 0, "R5 s3 window is one 8MB unit");

        // Same-cycle lookup and span-collapsing write on socket 3.
        @(posedge clk);
        #1;
        addr    = 32'h0400_0000;
        cfg_we  = 1'b1;
        cfg_idx = 3'd4;
        cfg_end = 5'd8;
        push(1, 3, 32'h0, "R9 old mapping before edge");
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        push(0, 0, 0, "R9 new mapping after edge");

        // Entries 0 and 7, and unpopulated socket 4.
        wr(3'd0, 5'd31);
        wr(3'd7, 5'd3);
        look(32'h0000_0010, 1, 0, 32'h0000_0010, "R6 entry0/7 no effect");
        look(32'h0200_0004, 1, 1, 32'h0000_0004, "R6 entry0/7 no effect");
        wr(3'd5, 5'd20);
        look(32'h0A00_0000, 0, 0, 0, "R6 unpopulated socket ignored");

        // Overlap: s0 [0,4), s1 [2,6) units.
        wr(3'd1, 5'd2);
        wr(3'd2, 5'd6);
        look(32'h0100_0000, 1, 1, 32'h0, "R7 higher socket wins");
        look(32'h0080_0000, 1, 0, 32'h0080_0000, "R7 low part s0 only");
        look(32'h0280_0000, 1, 1, 32'h0180_0000, "R8 offset from base");
        look(32'h0300_0000, 0, 0, 0, "R8 miss");

        // Auto layout with writes overlapping the walk.
        @(posedge clk);
        #1;
        rst_n    = 1'b0;
        auto_cfg = 1'b1;
        pop_code = 12'h05A;
        repeat (3) @(posedge clk);
        #1;
        rst_n   = 1'b1;
        cfg_we  = 1'b1;
        cfg_idx = 3'd1;
        cfg_end = 5'd0;
        addr    = 32'h0;
        push(0, 0, 0, "R3 quiet during layout");
        for (int i = 0; i < 6; i++) look(32'h0, 0, 0, 0, "R3 quiet during layout");
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        look(32'h0000_0000, 1, 0, 32'h0, "R3 write during layout ignored");
        look(32'h0200_0000, 1, 1, 32'h0, "R2 s1 at 32MB");
        look(32'h0400_0000, 1, 2, 32'h0, "R2 s2 at 64MB");
        look(32'h0480_0000, 1, 3, 32'h0, "R2 s3 at 72MB");
        look(32'h0500_0000, 0, 0, 0, "R2 end of layout");

        // Auto layout with only one 8 MB pair.
        do_reset(1'b1, 12'h005);
        look(32'h007F_FFFF, 1, 0, 32'h007F_FFFF, "R2 small s0");
        look(32'h0080_0004, 1, 1, 32'h0000_0004, "R2 small s1");
        look(32'h0100_0000, 0, 0, 0, "R2 small end");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule